// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave Controller

This block is the slave side of a two-wire serial bus in front of a 2048-byte memory held in a register file. SCL and SDA come in as raw levels sampled by the core clock. The block finds start and stop conditions and shifts bytes in on rising SCL edges. It drives SDA only by pulling it low, through an open-drain enable. It answers only when the device-select bits in the first byte agree with three strap pins. In that comparison the middle select bit must be the inverse of its pin.

A write transaction carries a word address and up to one page of data bytes. The data is held in a page staging buffer and goes to the array when the stop condition arrives. A self-timed write period then starts, counted in clock cycles. For that whole period the block stays off the bus. A read transaction returns bytes from an internal address counter until the master declines to acknowledge.

Top module: `eep2w_slave`

## Requirements
- R1: The first byte after a start is, MSB first: a 1, select bit 2, select bit 1, select bit 0, address bits 10..8, then R/W. The block acknowledges only if bit 7 is 1, bit 6 equals sel_strap[2], bit 5 equals the inverse of sel_strap[1], and bit 4 equals sel_strap[0]. After a mismatch it acknowledges nothing until the next start.
- R2: An acknowledge pulls SDA low during the ninth SCL clock after the matching address byte, after the word-address byte and after every data byte of a write. SDA is released at the falling SCL edge that ends that clock. A pull-low may begin only while SCL is low.
- R3: The array location is 11 bits wide. Bits 10..8 come from bits 3..1 of the address byte, and bits 7..0 come from the word-address byte.
- R4: Written data reaches the array only at a stop condition. A stop after at least one data byte starts a write period of WRITE_CYCLES clocks.
- R5: During the write period the block does not acknowledge, not even its own address, and keeps SDA released. After the period it responds again.
- R6: Within one write, the location advances only in its low PAGE_W bits and wraps inside the current page of 2^PAGE_W bytes.
- R7: A write that ends with a stop right after the word address sets the address counter and starts no write period.
- R8: A read (R/W = 1) takes bits 10..8 of the counter from the address byte. It sends the addressed byte MSB first, then advances the counter across the full 11-bit space, crossing page and block boundaries.
- R9: After a master acknowledge (SDA low in the ninth clock) the next byte follows. After a master no-acknowledge the block releases SDA and sends nothing more.
- R10: A start condition at any point, even in the middle of a byte, restarts address reception. Write data not yet committed is discarded, so no write period follows.
- R11: After reset SDA is released, the array holds all zeros and no write period is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Raw serial clock level |
| sda_in | input | 1 | Raw serial data level (wired bus) |
| sel_strap | input | 3 | Device-select strap pins |
| sda_pull_low | output | 1 | 1 = pull SDA low, 0 = release |

## Verification
The bench builds the block with WRITE_CYCLES = 200, PAGE_W = 4 and SYNC_STAGES = 2. At 200 clocks, both the refused address inside the write period and the acknowledged one after it fit into a few hundred cycles, instead of half a million. The 16-byte page makes a wrap from the last two locations of a page back to its start reachable with a four-byte write. The reads that follow show that reads, unlike writes, carry on into the next page and into the next 256-byte block.

// File: rtl/eep2w_pkg.sv
package eep2w_pkg;
   localparam int ADDR_W = 11;
   localparam int HI_W   = ADDR_W - 8;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_DEV,
      ST_WADR,
      ST_WDAT,
      ST_ACK,
      ST_RDAT,
      ST_RACK,
      ST_RLOAD
   } xfer_state_t;
endpackage

// File: rtl/eep2w_line_sync.sv
module eep2w_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_raw,
   input  logic sda_raw,
   output logic scl_lvl,
   output logic sda_lvl,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_pulse,
   output logic stop_pulse
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("eep2w_line_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] scl_pipe, sda_pipe;
   logic              scl_prev, sda_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_pipe <= '1;
         sda_pipe <= '1;
         scl_prev <= 1'b1;
         sda_prev <= 1'b1;
      end else begin
         scl_pipe <= {scl_pipe[STAGES-2:0], scl_raw};
         sda_pipe <= {sda_pipe[STAGES-2:0], sda_raw};
         scl_prev <= scl_pipe[STAGES-1];
         sda_prev <= sda_pipe[STAGES-1];
      end
   end

   assign scl_lvl     = scl_pipe[STAGES-1];
   assign sda_lvl     = sda_pipe[STAGES-1];
   assign scl_rise    = scl_lvl & ~scl_prev;
   assign scl_fall    = ~scl_lvl & scl_prev;
   assign start_pulse = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
   assign stop_pulse  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;
endmodule

// File: rtl/eep2w_wtimer.sv
module eep2w_wtimer #(
   parameter int WRITE_CYCLES = 500000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   output logic busy
);
   localparam int CW = $clog2(WRITE_CYCLES + 1);

   generate
      if (WRITE_CYCLES < 1) begin : g_bad_cycles
         $error("eep2w_wtimer: WRITE_CYCLES must be positive");
      end
   endgenerate

   logic [CW-1:0] remain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         remain <= '0;
      else if (load)
         remain <= CW'(WRITE_CYCLES);
      else if (remain != '0)
         remain <= remain - 1'b1;
   end

   assign busy = (remain != '0);

   AST_LOAD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> !busy); // R5
endmodule

// File: rtl/eep2w_array.sv
module eep2w_array #(
   parameter int ADDR_W = 11,
   parameter int PAGE_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              stage_en,
   input  logic [PAGE_W-1:0] stage_idx,
   input  logic [7:0]        stage_data,
   input  logic              discard,
   input  logic              commit,
   input  logic [ADDR_W-PAGE_W-1:0] commit_page,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [7:0]        rd_data
);
   localparam int DEPTH = 1 << ADDR_W;
   localparam int PAGE  = 1 << PAGE_W;

   generate
      if (PAGE_W < 1 || PAGE_W > 8) begin : g_bad_page
         $error("eep2w_array: PAGE_W must lie in 1..8");
      end
   endgenerate

   logic [7:0]      mem  [DEPTH];
   logic [7:0]      pbuf [PAGE];
   logic [PAGE-1:0] pvld;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
         for (int i = 0; i < PAGE; i++) pbuf[i] <= '0;
         pvld <= '0;
      end else if (commit) begin
         for (int i = 0; i < PAGE; i++)
            if (pvld[i]) mem[{commit_page, PAGE_W'(i)}] <= pbuf[i];
         pvld <= '0;
      end else if (discard) begin
         pvld <= '0;
      end else if (stage_en) begin
         pbuf[stage_idx] <= stage_data;
         pvld[stage_idx] <= 1'b1;
      end
   end

   assign rd_data = mem[rd_addr];

   AST_COMMIT_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      commit |-> (pvld != '0)); // R4
endmodule

// File: rtl/eep2w_ctrl.sv
module eep2w_ctrl
   import eep2w_pkg::*;
#(
   parameter int PAGE_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_lvl,
   input  logic              sda_lvl,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              start_det,
   input  logic              stop_det,
   input  logic [2:0]        strap,
   input  logic              busy,
   input  logic [7:0]        rd_data,
   output logic              drive_low,
   output logic              stage_en,
   output logic [PAGE_W-1:0] stage_idx,
   output logic [7:0]        stage_data,
   output logic              discard,
   output logic              commit,
   output logic [ADDR_W-PAGE_W-1:0] commit_page,
   output logic [ADDR_W-1:0] rd_addr
);
   xfer_state_t       state, after_ack;
   logic [2:0]        bitcnt;
   logic              rx_full;
   logic [7:0]        sr;
   logic [ADDR_W-1:0] addr;
   logic [HI_W-1:0]   hi;
   logic              wr_seen;
   logic              dev_match;

   assign dev_match = sr[7] && (sr[6] == strap[2]) && (sr[5] == ~strap[1])
                      && (sr[4] == strap[0]);

   assign stage_en    = !busy && !start_det && !stop_det && (state == ST_WDAT)
                        && scl_fall && rx_full;
   assign stage_idx   = addr[PAGE_W-1:0];
   assign stage_data  = sr;
   assign discard     = start_det && !busy;
   assign commit      = stop_det && !busy && wr_seen;
   assign commit_page = addr[ADDR_W-1:PAGE_W];
   assign rd_addr     = addr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         after_ack <= ST_IDLE;
         bitcnt    <= '0;
         rx_full   <= 1'b0;
         sr        <= '0;
         addr      <= '0;
         hi        <= '0;
         wr_seen   <= 1'b0;
         drive_low <= 1'b0;
      end else if (busy) begin
         state     <= ST_IDLE;
         rx_full   <= 1'b0;
         wr_seen   <= 1'b0;
         drive_low <= 1'b0;
      end else if (start_det) begin
         state     <= ST_DEV;
         bitcnt    <= '0;
         rx_full   <= 1'b0;
         wr_seen   <= 1'b0;
         drive_low <= 1'b0;
      end else if (stop_det) begin
         state     <= ST_IDLE;
         rx_full   <= 1'b0;
         wr_seen   <= 1'b0;
         drive_low <= 1'b0;
      end else begin
         unique case (state)
            ST_DEV, ST_WADR, ST_WDAT: begin
               if (scl_rise) begin
                  sr     <= {sr[6:0], sda_lvl};
                  bitcnt <= bitcnt + 1'b1;
                  if (bitcnt == 3'd7) rx_full <= 1'b1;
               end else if (scl_fall && rx_full) begin
                  rx_full <= 1'b0;
                  if (state == ST_DEV) begin
                     if (dev_match) begin
                        hi        <= sr[3:1];
                        drive_low <= 1'b1;
                        state     <= ST_ACK;
                        if (sr[0]) begin
                           addr[ADDR_W-1 -: HI_W] <= sr[3:1];
                           after_ack <= ST_RDAT;
                        end else begin
                           after_ack <= ST_WADR;
                        end
                     end else begin
                        state <= ST_IDLE;
                     end
                  end else if (state == ST_WADR) begin
                     addr      <= {hi, sr};
                     drive_low <= 1'b1;
                     state     <= ST_ACK;
                     after_ack <= ST_WDAT;
                  end else begin
                     addr[PAGE_W-1:0] <= addr[PAGE_W-1:0] + 1'b1;
                     wr_seen   <= 1'b1;
                     drive_low <= 1'b1;
                     state     <= ST_ACK;
                     after_ack <= ST_WDAT;
                  end
               end
            end
            ST_ACK, ST_RLOAD: begin
               if (scl_fall) begin
                  bitcnt <= '0;
                  if (state == ST_RLOAD || after_ack == ST_RDAT) begin
                     sr        <= rd_data;
                     drive_low <= ~rd_data[7];
                     addr      <= addr + 1'b1;
                     state     <= ST_RDAT;
                  end else begin
                     drive_low <= 1'b0;
                     state     <= after_ack;
                  end
               end
            end
            ST_RDAT: begin
               if (scl_fall) begin
                  if (bitcnt == 3'd7) begin
                     drive_low <= 1'b0;
                     state     <= ST_RACK;
                  end else begin
                     sr        <= {sr[6:0], 1'b0};
                     drive_low <= ~sr[6];
                     bitcnt    <= bitcnt + 1'b1;
                  end
               end
            end
            ST_RACK: begin
               if (scl_rise) state <= sda_lvl ? ST_IDLE : ST_RLOAD;
            end
            default: ;
         endcase
      end
   end

   AST_PULL_STARTS_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(drive_low) |-> !scl_lvl); // R2
endmodule

// File: rtl/eep2w_slave.sv
module eep2w_slave
   import eep2w_pkg::*;
#(
   parameter int PAGE_W       = 4,
   parameter int WRITE_CYCLES = 500000,
   parameter int SYNC_STAGES  = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_in,
   input  logic       sda_in,
   input  logic [2:0] sel_strap,
   output logic       sda_pull_low
);
   logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
   logic busy, stage_en, discard, commit;
   logic [PAGE_W-1:0]        stage_idx;
   logic [7:0]               stage_data, rd_data;
   logic [ADDR_W-PAGE_W-1:0] commit_page;
   logic [ADDR_W-1:0]        rd_addr;

   eep2w_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .scl_raw(scl_in), .sda_raw(sda_in),
      .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
      .scl_fall(scl_fall), .start_pulse(start_det), .stop_pulse(stop_det));

   eep2w_ctrl #(.PAGE_W(PAGE_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .scl_lvl(scl_lvl), .sda_lvl(sda_lvl),
      .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det),
      .stop_det(stop_det), .strap(sel_strap), .busy(busy), .rd_data(rd_data),
      .drive_low(sda_pull_low), .stage_en(stage_en), .stage_idx(stage_idx),
      .stage_data(stage_data), .discard(discard), .commit(commit),
      .commit_page(commit_page), .rd_addr(rd_addr));

   eep2w_wtimer #(.WRITE_CYCLES(WRITE_CYCLES)) u_timer (
      .clk(clk), .rst_n(rst_n), .load(commit), .busy(busy));

   eep2w_array #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_array (
      .clk(clk), .rst_n(rst_n), .stage_en(stage_en), .stage_idx(stage_idx),
      .stage_data(stage_data), .discard(discard), .commit(commit),
      .commit_page(commit_page), .rd_addr(rd_addr), .rd_data(rd_data));

   AST_BUSY_AFTER_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> busy); // R4
   AST_QUIET_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !sda_pull_low); // R5
endmodule

// File: tb/eep2w_slave_test.sv
module eep2w_slave_test;
   localparam int WC = 200;
   localparam int Q  = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl_m = 1'b1;
   logic       sda_m = 1'b1;
   logic [2:0] strap = 3'b010;
   logic       pull;
   logic       sda_bus;
   int         checks = 0;
   int         errors = 0;

   assign sda_bus = sda_m & ~pull;

   always #5 clk = ~clk;

   eep2w_slave #(.PAGE_W(4), .WRITE_CYCLES(WC), .SYNC_STAGES(2)) uut (
      .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_bus),
      .sel_strap(strap), .sda_pull_low(pull));

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic wq();
      repeat (Q) @(negedge clk);
   endtask

   function automatic logic [7:0] dev(input logic [2:0] hi, input logic rw);
      return {1'b1, strap[2], ~strap[1], strap[0], hi, rw};
   endfunction

   task automatic bstart();
      sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
   endtask

   task automatic bstop();
      scl_m = 1'b0; wq(); sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
   endtask

   task automatic send_bit(input logic b);
      sda_m = b; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
   endtask

   task automatic send_byte(input logic [7:0] b, output logic ack);
      for (int i = 7; i >= 0; i--) send_bit(b[i]);
      sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); ack = ~sda_bus; wq(); scl_m = 1'b0; wq();
   endtask

   task automatic recv_byte(output logic [7:0] b, input logic mack);
      sda_m = 1'b1;
      for (int i = 0; i < 8; i++) begin
         wq(); scl_m = 1'b1; wq(); b = {b[6:0], sda_bus}; wq(); scl_m = 1'b0;
      end
      wq(); sda_m = ~mack; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
      sda_m = 1'b1;
   endtask

   task automatic set_addr(input logic [10:0] a);
      logic ack;
      bstart();
      send_byte(dev(a[10:8], 1'b0), ack); chk("R1", "dev ack", ack, 1);
      send_byte(a[7:0], ack);             chk("R2", "word addr ack", ack, 1);
   endtask

   task automatic write_bytes(input logic [10:0] a, input logic [7:0] d [], input int n);
      logic ack;
      set_addr(a);
      for (int i = 0; i < n; i++) begin
         send_byte(d[i], ack); chk("R2", "data ack", ack, 1);
      end
      bstop();
      repeat (WC + 40) @(negedge clk);
   endtask

   task automatic read_from(input logic [10:0] a, input int n, input logic [7:0] exp [], input string req);
      logic ack;
      logic [7:0] b;
      set_addr(a);
      bstart();
      send_byte(dev(a[10:8], 1'b1), ack); chk("R8", "read dev ack", ack, 1);
      for (int i = 0; i < n; i++) begin
         recv_byte(b, i != n - 1);
         chk(req, $sformatf("read byte %0d", i), b, exp[i]);
      end
      bstop();
   endtask

   task automatic t_reset();
      logic [7:0] e [] = '{8'h00};
      chk("R11", "SDA released after reset", pull, 0);
      read_from(11'h7FF, 1, e, "R11");
   endtask

   task automatic t_match();
      logic ack;
      bstart(); send_byte(dev(3'd0, 1'b0), ack); chk("R1", "matching address", ack, 1); bstop();
      bstart(); send_byte(8'b1010_0000, ack); chk("R1", "select bit 1 not inverted", ack, 0);
      send_byte(8'h00, ack); chk("R1", "byte after mismatch", ack, 0); bstop();
      bstart(); send_byte(8'b1001_0000, ack); chk("R1", "select bit 0 wrong", ack, 0); bstop();
      bstart(); send_byte(8'b1100_0000, ack); chk("R1", "select bit 2 wrong", ack, 0); bstop();
      bstart(); send_byte(8'b0000_0000, ack); chk("R1", "leading bit zero", ack, 0); bstop();
   endtask

   task automatic t_byte_write();
      logic ack;
      logic [7:0] e [] = '{8'h3C};
      logic [7:0] z [] = '{8'h00};
      set_addr(11'h5A3);
      send_byte(8'h3C, ack); chk("R2", "data ack", ack, 1);
      chk("R2", "SDA released after ack clock", pull, 0);
      bstop();
      bstart(); send_byte(dev(3'd5, 1'b0), ack); chk("R5", "address during write period", ack, 0);
      chk("R5", "SDA released during write period", pull, 0);
      bstop();
      repeat (WC + 40) @(negedge clk);
      bstart(); send_byte(dev(3'd5, 1'b0), ack); chk("R5", "address after write period", ack, 1); bstop();
      set_addr(11'h5A3); bstop();
      bstart(); send_byte(dev(3'd5, 1'b0), ack); chk("R7", "no write period after address only", ack, 1); bstop();
      read_from(11'h5A3, 1, e, "R3");
      read_from(11'h1A3, 1, z, "R3");
      set_addr(11'h5A3);
      bstart(); send_byte(dev(3'd5, 1'b1), ack);
      begin
         logic [7:0] b;
         recv_byte(b, 1'b0); chk("R9", "byte before no-ack", b, 8'h3C);
         repeat (Q) @(negedge clk);
         chk("R9", "SDA released after master no-ack", pull, 0);
      end
      bstop();
   endtask

   task automatic t_page();
      logic [7:0] d [] = '{8'hD0, 8'hD1, 8'hD2, 8'hD3};
      logic [7:0] e1 [] = '{8'hD2, 8'hD3, 8'h00};
      logic [7:0] e2 [] = '{8'hD0, 8'hD1, 8'h00};
      write_bytes(11'h12E, d, 4);
      read_from(11'h120, 3, e1, "R6");
      read_from(11'h12E, 3, e2, "R6");
   endtask

   task automatic t_cross();
      logic ack;
      logic [7:0] b;
      logic [7:0] d1 [] = '{8'h11};
      logic [7:0] d2 [] = '{8'h22};
      logic [7:0] d3 [] = '{8'h5E};
      logic [7:0] e [] = '{8'h11, 8'h22};
      write_bytes(11'h0FF, d1, 1);
      write_bytes(11'h100, d2, 1);
      write_bytes(11'h301, d3, 1);
      read_from(11'h0FF, 2, e, "R8");
      bstart(); send_byte(dev(3'd3, 1'b1), ack); chk("R8", "current read ack", ack, 1);
      recv_byte(b, 1'b0); chk("R8", "current read takes high bits from address byte", b, 8'h5E);
      bstop();
   endtask

   task automatic t_abort();
      logic ack;
      logic [7:0] z [] = '{8'h00};
      bstart();
      for (int i = 7; i >= 4; i--) send_bit(1'b1);
      bstart();
      send_byte(dev(3'd2, 1'b0), ack); chk("R10", "address after mid-byte start", ack, 1);
      send_byte(8'h40, ack); chk("R10", "word address after restart", ack, 1);
      send_byte(8'h77, ack); chk("R10", "data before abort", ack, 1);
      bstart();
      bstop();
      bstart(); send_byte(dev(3'd2, 1'b0), ack); chk("R10", "no write period after abort", ack, 1); bstop();
      read_from(11'h240, 1, z, "R10");
   endtask

   initial begin
      repeat (10) @(negedge clk);
      rst_n = 1'b1;
      repeat (10) @(negedge clk);
      t_reset();
      t_match();
      t_byte_write();
      t_page();
      t_cross();
      t_abort();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (180000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule